// File: doc/BRIEF.md
# Selectable-Ratio Serial Bit-Rate Generator

This block produces the timing strobes that pace one serial channel. A shared programmable divider counts ticks of a chosen source, either every cycle of the system clock or cycles on which an external clock enable is high. Every N+1 source ticks it emits a sample strobe. Each direction then divides that sample rate again by its own oversampling ratio of x1, x8, x16 or x32 to form a bit strobe. Asynchronous links use equal transmit and receive ratios of x8, x16 or x32. Synchronous links use x1 in both directions.

A master enable gates the whole generator. An optional drive flag produces a transmit clock waveform for a synchronous master to put on a pin. That waveform rises with each transmit bit strobe and falls at the divider midpoint. Any change to the divide value, either ratio or the source select restarts every counter, so no shortened period follows a reprogramming. The external source is taken as an enable that is already synchronous to the system clock.

Top module: `serial_rate_gen`

## Requirements
- R1: While genEnable is low, all four strobes and txClkOut are low from the following cycle on.
- R2: With srcSelect=0 (system clock source), the sample strobes are one-cycle pulses every divN+1 cycles. After genEnable rises, the first pulse is high on the cycle after the (divN+1)-th rising edge.
- R3: With srcSelect=1, only cycles with extTick high advance the divider. The sample strobe pulses on the cycle after every (divN+1)-th such tick.
- R4: The ratio code on txRatio and rxRatio is 0 for x1, 1 for x8, 2 for x16 and 3 for x32. A bit strobe is high together with every ratio-th sample strobe of its direction, starting with the ratio-th one. In x1 every sample strobe is also a bit strobe.
- R5: Both directions share one divider, so txSampleStb equals rxSampleStb. Each direction applies its own ratio independently of the other.
- R6: A change of divN, txRatio, rxRatio or srcSelect while enabled clears all counters. No strobe is high on the cycle after the change. The next sample strobe follows divN+1 source ticks later.
- R7: With txExtDrive high and the generator enabled, txClkOut goes high together with each txBitStb pulse. It goes low on the cycle after a source tick at divider count divN>>1, unless a transmit bit strobe occurs at that tick.
- R8: While txExtDrive is low, txClkOut is low from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| genEnable | input | 1 | Master enable of the generator |
| srcSelect | input | 1 | Source select: 0 system clock, 1 external tick |
| extTick | input | 1 | External source enable, synchronous to clk |
| divN | input | DIV_W | Divider value N; sample period is N+1 source ticks |
| txRatio | input | 2 | Transmit oversampling code (0 x1, 1 x8, 2 x16, 3 x32) |
| rxRatio | input | 2 | Receive oversampling code (0 x1, 1 x8, 2 x16, 3 x32) |
| txExtDrive | input | 1 | Enables the transmit clock output waveform |
| txSampleStb | output | 1 | Transmit sample strobe |
| txBitStb | output | 1 | Transmit bit strobe |
| rxSampleStb | output | 1 | Receive sample strobe |
| rxBitStb | output | 1 | Receive bit strobe |
| txClkOut | output | 1 | Transmit clock for synchronous master use, idle low |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that extTick is already synchronous to clk, and that a reprogramming is seen as a difference between consecutive cycles. The bench changes every input half a cycle away from the rising edge. It produces the external tick itself on a fixed one-in-three cycle pattern. Every reprogramming either happens while the generator is disabled or is one deliberate change of a single field while it runs. Under these conditions the expected strobe positions follow from tick counts alone.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int SAMP_W = 5;

  typedef struct packed {
    logic clear;
    logic sampleTick;
    logic midTick;
  } gen_ctl_t;

  function automatic logic [SAMP_W-1:0] ratioLast(input logic [1:0] code);
    case (code)
      2'd0:    return SAMP_W'(0);
      2'd1:    return SAMP_W'(7);
      2'd2:    return SAMP_W'(15);
      default: return SAMP_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/srg_ctrl.sv
module srg_ctrl
  import srg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             genEnable,
  input  logic             srcSelect,
  input  logic             extTick,
  input  logic [DIV_W-1:0] divN,
  input  logic [1:0]       txRatio,
  input  logic [1:0]       rxRatio,
  output gen_ctl_t         ctl
);
  localparam int CFG_W = DIV_W + 5;

  logic [CFG_W-1:0] cfgNow;
  logic [CFG_W-1:0] cfgQ;
  logic [DIV_W-1:0] divCnt;
  logic             cfgChange;
  logic             srcTick;
  logic             clearNow;

  assign cfgNow    = {srcSelect, txRatio, rxRatio, divN};
  assign cfgChange = (cfgNow != cfgQ);
  assign srcTick   = srcSelect ? extTick : 1'b1;
  assign clearNow  = !genEnable || cfgChange;

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearNow) divCnt <= '0;
    else if (srcTick)      divCnt <= (divCnt == divN) ? '0 : divCnt + 1'b1;
  end

  always_comb begin
    ctl.clear      = clearNow;
    ctl.sampleTick = !clearNow && srcTick && (divCnt == divN);
    ctl.midTick    = !clearNow && srcTick && (divCnt == (divN >> 1));
  end
endmodule

// File: rtl/srg_datapath.sv
module srg_datapath
  import srg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  gen_ctl_t ctl,
  input  logic [1:0] txRatio,
  input  logic [1:0] rxRatio,
  input  logic     txExtDrive,
  output logic     txSampleStb,
  output logic     txBitStb,
  output logic     rxSampleStb,
  output logic     rxBitStb,
  output logic     txClkOut
);
  localparam int NDIR = 2;

  logic [1:0] ratioSel  [NDIR];
  logic       bitTick   [NDIR];
  logic       sampleStbQ[NDIR];
  logic       bitStbQ   [NDIR];
  logic       clkOutQ;

  assign ratioSel[0] = txRatio;
  assign ratioSel[1] = rxRatio;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [SAMP_W-1:0] sampCnt;
    logic [SAMP_W-1:0] lastIdx;

    assign lastIdx    = ratioLast(ratioSel[d]);
    assign bitTick[d] = ctl.sampleTick && (sampCnt == lastIdx);

    always_ff @(posedge clk) begin
      if (!rstN || ctl.clear) sampCnt <= '0;
      else if (ctl.sampleTick) sampCnt <= (sampCnt == lastIdx) ? '0 : sampCnt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sampleStbQ[d] <= 1'b0;
        bitStbQ[d]    <= 1'b0;
      end else begin
        sampleStbQ[d] <= ctl.sampleTick;
        bitStbQ[d]    <= bitTick[d];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear || !txExtDrive) clkOutQ <= 1'b0;
    else if (bitTick[0])                  clkOutQ <= 1'b1;
    else if (ctl.midTick)                 clkOutQ <= 1'b0;
  end

  assign txSampleStb = sampleStbQ[0];
  assign txBitStb    = bitStbQ[0];
  assign rxSampleStb = sampleStbQ[1];
  assign rxBitStb    = bitStbQ[1];
  assign txClkOut    = clkOutQ;
endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import srg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             genEnable,
  input  logic             srcSelect,
  input  logic             extTick,
  input  logic [DIV_W-1:0] divN,
  input  logic [1:0]       txRatio,
  input  logic [1:0]       rxRatio,
  input  logic             txExtDrive,
  output logic             txSampleStb,
  output logic             txBitStb,
  output logic             rxSampleStb,
  output logic             rxBitStb,
  output logic             txClkOut
);
  gen_ctl_t ctl;

  srg_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .genEnable(genEnable), .srcSelect(srcSelect),
    .extTick(extTick), .divN(divN), .txRatio(txRatio), .rxRatio(rxRatio),
    .ctl(ctl)
  );

  srg_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txRatio(txRatio), .rxRatio(rxRatio),
    .txExtDrive(txExtDrive), .txSampleStb(txSampleStb), .txBitStb(txBitStb),
    .rxSampleStb(rxSampleStb), .rxBitStb(rxBitStb), .txClkOut(txClkOut)
  );
endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             genEnable,
  input logic [DIV_W-1:0] divN,
  input logic [1:0]       txRatio,
  input logic             txExtDrive,
  input logic             txSampleStb,
  input logic             txBitStb,
  input logic             rxSampleStb,
  input logic             rxBitStb,
  input logic             txClkOut
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !genEnable |=> !txSampleStb && !txBitStb && !rxSampleStb && !rxBitStb && !txClkOut); // R1

  AST_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    (txSampleStb && divN != '0) |=> !txSampleStb); // R2

  AST_TX_BIT_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    txBitStb |-> txSampleStb); // R4

  AST_RX_BIT_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    rxBitStb |-> rxSampleStb); // R4

  AST_X1_EVERY_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (txSampleStb && $past(txRatio) == 2'd0) |-> txBitStb); // R4

  AST_SAMPLE_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    txSampleStb == rxSampleStb); // R5

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divN) |=> !txSampleStb && !rxSampleStb); // R6

  AST_CLK_RISE_ON_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txClkOut) |-> txBitStb); // R7

  AST_NO_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !txExtDrive |=> !txClkOut); // R8
endmodule

bind serial_rate_gen srg_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .genEnable(genEnable), .divN(divN), .txRatio(txRatio),
  .txExtDrive(txExtDrive), .txSampleStb(txSampleStb), .txBitStb(txBitStb),
  .rxSampleStb(rxSampleStb), .rxBitStb(rxBitStb), .txClkOut(txClkOut)
);

// File: tb/serial_rate_gen_bench.sv
module serial_rate_gen_bench;
  localparam int DIV_W  = 12;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic genEnable = 1'b0, srcSelect = 1'b0, extTick = 1'b0, txExtDrive = 1'b0;
  logic [DIV_W-1:0] divN = '0;
  logic [1:0] txRatio = 2'd0, rxRatio = 2'd0;
  logic txSampleStb, txBitStb, rxSampleStb, rxBitStb, txClkOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  serial_rate_gen #(.DIV_W(DIV_W)) u_serial_rate_gen (
    .clk(clk), .rstN(rstN), .genEnable(genEnable), .srcSelect(srcSelect),
    .extTick(extTick), .divN(divN), .txRatio(txRatio), .rxRatio(rxRatio),
    .txExtDrive(txExtDrive), .txSampleStb(txSampleStb), .txBitStb(txBitStb),
    .rxSampleStb(rxSampleStb), .rxBitStb(rxBitStb), .txClkOut(txClkOut)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int lenOf(input int code);
    return (code == 0) ? 1 : (1 << (code + 2));
  endfunction

  function automatic logic expSample(input int s, input int n);
    return (s > 0) && ((s % (n + 1)) == 0);
  endfunction

  function automatic logic expBit(input int s, input int n, input int len);
    return expSample(s, n) && (((s / (n + 1)) % len) == 0);
  endfunction

  // Start from disabled with a fixed config; src=1 uses a tick on every edge j with j%3==2.
  task automatic sweepCase(input int n, input int txr, input int rxr, input int src);
    int len;
    string rs;
    rs = (src != 0) ? "R3" : "R2";
    @(negedge clk);
    genEnable = 1'b0; extTick = 1'b0;
    divN = DIV_W'(n); txRatio = 2'(txr); rxRatio = 2'(rxr); srcSelect = 1'(src);
    txExtDrive = (src == 0 && txr == 0);
    repeat (2) @(negedge clk);
    genEnable = 1'b1;
    extTick = 1'b0;
    len = (n + 1) * 32 * ((src != 0) ? 3 : 1) + 6;
    for (int j = 0; j < len; j++) begin
      logic es, etb, erb, eclk;
      int p;
      @(negedge clk);
      if (src == 0) begin
        es  = expSample(j + 1, n);
        etb = expBit(j + 1, n, lenOf(txr));
        erb = expBit(j + 1, n, lenOf(rxr));
      end else begin
        es  = (j % 3 == 2) && expSample((j + 1) / 3, n);
        etb = (j % 3 == 2) && expBit((j + 1) / 3, n, lenOf(txr));
        erb = (j % 3 == 2) && expBit((j + 1) / 3, n, lenOf(rxr));
      end
      chk(rs, "txSampleStb", txSampleStb, es);
      chk("R5", "rxSampleStb", rxSampleStb, es);
      chk("R4", "txBitStb", txBitStb, etb);
      chk("R5", "rxBitStb", rxBitStb, erb);
      p = j % (n + 1);
      if (txExtDrive) begin
        eclk = (j >= n) && ((p == n) || (p < (n >> 1)));
        chk("R7", "txClkOut", txClkOut, eclk);
      end else begin
        chk("R8", "txClkOut", txClkOut, 1'b0);
      end
      extTick = ((j + 1) % 3 == 2);
    end
  endtask

  // Run a while, then change one field; counting restarts from the change edge.
  task automatic restartCase(input int n0, input int n1, input int txr0, input int txr1, input int rxr);
    @(negedge clk);
    genEnable = 1'b0; srcSelect = 1'b0; txExtDrive = 1'b0;
    divN = DIV_W'(n0); txRatio = 2'(txr0); rxRatio = 2'(rxr);
    repeat (2) @(negedge clk);
    genEnable = 1'b1;
    repeat (7) @(negedge clk);
    divN = DIV_W'(n1); txRatio = 2'(txr1);
    for (int k = 0; k < (n1 + 1) * 32 + 6; k++) begin
      @(negedge clk);
      chk("R6", "txSampleStb", txSampleStb, expSample(k, n1));
      chk("R6", "rxSampleStb", rxSampleStb, expSample(k, n1));
      chk("R6", "txBitStb", txBitStb, expBit(k, n1, lenOf(txr1)));
      chk("R6", "rxBitStb", rxBitStb, expBit(k, n1, lenOf(rxr)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "txSampleStb reset", txSampleStb, 1'b0);
    chk("R1", "txClkOut reset", txClkOut, 1'b0);
    rstN = 1'b1;

    // R1: disabled with the fastest config and clock drive on
    @(negedge clk);
    genEnable = 1'b0; divN = '0; txRatio = 2'd0; rxRatio = 2'd0; txExtDrive = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk("R1", "txSampleStb off", txSampleStb, 1'b0);
      chk("R1", "rxSampleStb off", rxSampleStb, 1'b0);
      chk("R1", "txBitStb off", txBitStb, 1'b0);
      chk("R1", "rxBitStb off", rxBitStb, 1'b0);
      chk("R1", "txClkOut off", txClkOut, 1'b0);
    end

    for (int src = 0; src < 2; src++)
      for (int n = 0; n < 5; n++)
        for (int t = 0; t < 4; t++)
          for (int r = 0; r < 4; r++)
            sweepCase(n, t, r, src);

    restartCase(4, 2, 0, 0, 1);
    restartCase(3, 0, 1, 1, 2);
    restartCase(2, 2, 1, 3, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule